// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is a synthesizable arithmetic slice of the kind used to build FIR filters and accumulators. It forms a pre-adder sum or difference of two 25-bit signed operands. It multiplies that value by an 18-bit signed operand. A 48-bit post-adder then combines the product with a selectable Z operand. A 5-bit mode word, sampled together with the data, chooses three things: one of four Z sources, one of four post-adder sign forms, and whether the pre-adder subtracts.

The datapath is a fixed register pipeline: two input stages, a product register and a result register. Each has its own clock enable. A full-width cascade output lets several slices be chained through the cascade input of the next slice. A parameter drops low-order bits from the visible result only.

Top module: `preadd_mac_slice`

## Requirements
- R1: With all enables high, a product of `a` and `b` (signed, sign-extended to 48 bits) shows on `pcout` at the 4th rising edge after the cycle in which `a`, `b`, `c` and `mode` were applied.
- R2: `mode[1:0]` selects the post-adder form, with M the product and Z the selected operand: 0 gives Z+M, 1 gives M−Z, 2 gives −(Z+M+1), 3 gives Z−M.
- R3: `mode[3:2]` selects Z: 0 selects zero, 1 selects `pcin` as sampled at the result edge, 2 selects the current result register, 3 selects `c` as applied with `a`.
- R4: When `USE_PREADD` is 1, the multiplier operand is `a+d`, or `a−d` when `mode[4]` is 1, wrapped to 25 bits. `d` is sampled two cycles after `a`, at the edge that loads the product register.
- R5: When `USE_PREADD` is 0, the product is `a×b` and `d` has no effect.
- R6: Issuing one load (mode 5'b01100) and then accumulate operations (mode 5'b01000) on back-to-back cycles gives c+a0·b0 first, and then adds each later product on successive edges.
- R7: While `ce_p` is low the result holds. While `ce_a1` is low, the operands applied in that cycle are not captured.
- R8: All additions wrap modulo 2^48 with no saturation.
- R9: `p` equals `pcout[47:S]`, and `pcout` always carries the full 48-bit result.
- R10: A synchronous active-high `rst` clears every pipeline register, so `pcout` reads 0 after the reset edge, including when an operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_a1 | input | 1 | Enable of the first input stage (a, b, c, mode) |
| ce_a2 | input | 1 | Enable of the second input stage |
| ce_m | input | 1 | Enable of the product stage |
| ce_p | input | 1 | Enable of the result register |
| a | input | 25 | Signed pre-adder operand |
| d | input | 25 | Signed pre-adder operand, two stages later |
| b | input | 18 | Signed multiplier operand |
| c | input | 48 | Signed post-adder operand |
| pcin | input | 48 | Cascade input from a preceding slice |
| mode | input | 5 | Operation select |
| p | output | 48-S | Result with S low bits removed |
| pcout | output | 48 | Full 48-bit result |

## Verification
Two functions can act in the same cycle. The first is the load of a new accumulation through Z=C. The second is the feedback of the result register through Z=P, while the next operation is already in the pipeline. The bench issues a load and two accumulate operations on consecutive cycles, so that each result edge reads the value the previous edge has just written. It judges the three consecutive results against running sums computed in the bench. It also raises reset while an operation is partway through the pipeline, and checks that no trace of that operation reaches the output.

// File: rtl/preadd_mac_slice.sv
module preadd_mac_slice #(
  parameter int AW = 25,
  parameter int BW = 18,
  parameter int PW = 48,
  parameter int S = 0,
  parameter bit USE_PREADD = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce_a1,
  input  logic                 ce_a2,
  input  logic                 ce_m,
  input  logic                 ce_p,
  input  logic signed [24:0]   a,
  input  logic signed [24:0]   d,
  input  logic signed [17:0]   b,
  input  logic signed [47:0]   c,
  input  logic signed [47:0]   pcin,
  input  logic [4:0]           mode,
  output logic [47-S:0]        p,
  output logic [47:0]          pcout
);
  localparam int MW = AW + BW;

  logic signed [AW-1:0] a1, a2, pre, d_term;
  logic signed [BW-1:0] b1, b2;
  logic signed [PW-1:0] c1, c2, c3, z, m_ext, p_r, p_nxt;
  logic signed [MW-1:0] m_r;
  logic [4:0] md1, md2, md3;

  assign d_term = USE_PREADD ? (md2[4] ? -d : d) : '0;
  assign pre    = a2 + d_term;
  assign m_ext  = {{(PW-MW){m_r[MW-1]}}, m_r};

  always_comb begin
    case (md3[3:2])
      2'd0:    z = '0;
      2'd1:    z = pcin;
      2'd2:    z = p_r;
      default: z = c3;
    endcase
    case (md3[1:0])
      2'd0:    p_nxt = z + m_ext;
      2'd1:    p_nxt = m_ext - z;
      2'd2:    p_nxt = ~(z + m_ext);
      default: p_nxt = z - m_ext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a1 <= '0; b1 <= '0; c1 <= '0; md1 <= '0;
      a2 <= '0; b2 <= '0; c2 <= '0; md2 <= '0;
      m_r <= '0; c3 <= '0; md3 <= '0;
      p_r <= '0;
    end else begin
      if (ce_a1) begin
        a1 <= a; b1 <= b; c1 <= c; md1 <= mode;
      end
      if (ce_a2) begin
        a2 <= a1; b2 <= b1; c2 <= c1; md2 <= md1;
      end
      if (ce_m) begin
        m_r <= pre * b2; c3 <= c2; md3 <= md2;
      end
      if (ce_p) p_r <= p_nxt;
    end
  end

  assign pcout = p_r;
  assign p     = p_r[PW-1:S];

  AST_P_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ce_p |=> $stable(pcout)) else $error("result moved with ce_p low"); // R7

  AST_M_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ce_m |=> $stable(m_r)) else $error("product moved with ce_m low"); // R7

  AST_ACCUM: assert property (@(posedge clk) disable iff (rst)
    (ce_p && md3[3:0] == 4'b1000) |=> pcout == $past(pcout) + $past(m_ext))
    else $error("accumulate step wrong"); // R6

  AST_INV_FORM: assert property (@(posedge clk) disable iff (rst)
    (ce_p && md3[3:0] == 4'b0010) |=> pcout == ~$past(m_ext))
    else $error("inverted form wrong"); // R2

  AST_TRUNC: assert property (@(posedge clk) disable iff (rst)
    p == pcout[PW-1:S]) else $error("visible result not aligned"); // R9
endmodule

// File: tb/preadd_mac_slice_bench.sv
`timescale 1ns/1ps
module preadd_mac_slice_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic ce_a1 = 1'b1, ce_a2 = 1'b1, ce_m = 1'b1, ce_p = 1'b1;
  logic signed [24:0] a = '0, d = '0;
  logic signed [17:0] b = '0;
  logic signed [47:0] c = '0, pcin = 48'sd1000;
  logic [4:0] mode = '0;
  logic [47:0] p, pcout, pcout_n;
  logic [43:0] p_n;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  preadd_mac_slice u_preadd_mac_slice (.clk, .rst, .ce_a1, .ce_a2, .ce_m, .ce_p,
    .a, .d, .b, .c, .pcin, .mode, .p, .pcout);
  preadd_mac_slice #(.S(4), .USE_PREADD(1'b0)) u_preadd_mac_slice_n (.clk, .rst,
    .ce_a1, .ce_a2, .ce_m, .ce_p, .a, .d, .b, .c, .pcin, .mode, .p(p_n), .pcout(pcout_n));

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic signed [24:0] av, logic signed [17:0] bv,
                       logic signed [47:0] cv, logic signed [24:0] dv, logic [4:0] mv);
    @(negedge clk); a = av; b = bv; c = cv; mode = mv;
    @(negedge clk); a = '0; b = '0; c = '0; mode = '0;
    @(negedge clk); d = dv;
    @(negedge clk); d = '0;
    @(negedge clk);
  endtask

  task automatic flush();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 reset pcout", pcout, 48'd0);
    check("R10 reset p", p, 48'd0);
  endtask

  task automatic t_latency();
    issue(25'sd3, 18'sd5, 48'sd0, 25'sd0, 5'b00000);
    check("R1 3x5", pcout, 48'd15);
    flush();
    issue(-25'sd16777216, -18'sd131072, 48'sd0, 25'sd0, 5'b00000);
    check("R1 extreme product", pcout, 48'h0200_0000_0000);
    flush();
    issue(-25'sd7, 18'sd9, 48'sd0, 25'sd0, 5'b00000);
    check("R1 negative product", pcout, -48'sd63);
    flush();
  endtask

  task automatic t_forms();
    issue(25'sd3, 18'sd5, 48'sd100, 25'sd0, 5'b01100);
    check("R2 Z+M", pcout, 48'd115);  flush();
    issue(25'sd3, 18'sd5, 48'sd100, 25'sd0, 5'b01111);
    check("R2 Z-M", pcout, 48'd85);   flush();
    issue(25'sd3, 18'sd5, 48'sd100, 25'sd0, 5'b01101);
    check("R2 M-Z", pcout, -48'sd85); flush();
    issue(25'sd3, 18'sd5, 48'sd100, 25'sd0, 5'b01110);
    check("R2 -(Z+M+1)", pcout, -48'sd116); flush();
  endtask

  task automatic t_zsel();
    issue(25'sd3, 18'sd5, 48'sd100, 25'sd0, 5'b00100);
    check("R3 Z=cascade", pcout, 48'd1015); flush();
    issue(25'sd3, 18'sd5, 48'sd100, 25'sd0, 5'b00000);
    check("R3 Z=zero ignores c", pcout, 48'd15); flush();
  endtask

  task automatic t_preadd();
    issue(25'sd10, 18'sd4, 48'sd0, 25'sd3, 5'b10000);
    check("R4 a-d", pcout, 48'd28);
    check("R5 no preadd ignores d", pcout_n, 48'd40);
    flush();
    issue(25'sd10, 18'sd4, 48'sd0, 25'sd3, 5'b00000);
    check("R4 a+d", pcout, 48'd52);
    flush();
  endtask

  task automatic t_accum();
    @(negedge clk); a = 25'sd2; b = 18'sd3;  c = 48'sd10; mode = 5'b01100;
    @(negedge clk); a = 25'sd4; b = 18'sd5;  c = 48'sd0;  mode = 5'b01000;
    @(negedge clk); a = 25'sd1; b = -18'sd7; mode = 5'b01000;
    @(negedge clk); a = '0; b = '0; mode = 5'b00000;
    @(negedge clk); check("R6 load", pcout, 48'd16);
    @(negedge clk); check("R6 acc 1", pcout, 48'd36);
    @(negedge clk); check("R6 acc 2", pcout, 48'd29);
    flush();
  endtask

  task automatic t_enables();
    issue(25'sd3, 18'sd5, 48'sd0, 25'sd0, 5'b00000);
    check("R7 before hold", pcout, 48'd15);
    ce_p = 1'b0;
    issue(25'sd2, 18'sd2, 48'sd999, 25'sd0, 5'b01100);
    check("R7 ce_p low holds", pcout, 48'd15);
    ce_p = 1'b1;
    flush();
    @(negedge clk); a = 25'sd7; b = 18'sd7; mode = 5'b00000; ce_a1 = 1'b0;
    @(negedge clk); a = '0; b = '0; ce_a1 = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 ce_a1 low drops operands", pcout, 48'd0);
    flush();
  endtask

  task automatic t_wrap();
    issue(25'sd1, 18'sd1, 48'sh7FFF_FFFF_FFFF, 25'sd0, 5'b01100);
    check("R8 wrap", pcout, 48'h8000_0000_0000);
    flush();
  endtask

  task automatic t_trunc();
    issue(25'sd3, 18'sd5, 48'sh123, 25'sd0, 5'b01100);
    check("R9 full pcout", pcout_n, 48'h132);
    check("R9 p drops S bits", {4'd0, p_n}, 48'h13);
    flush();
  endtask

  task automatic t_reset_mid();
    @(negedge clk); a = 25'sd9; b = 18'sd9; mode = 5'b00000;
    @(negedge clk); a = '0; b = '0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset in flight", pcout, 48'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_forms();
    t_zsel();
    t_preadd();
    t_accum();
    t_enables();
    t_wrap();
    t_trunc();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule